// File: doc/BRIEF.md
# Timer-Reload Baud Serial Port

This block is a full-duplex asynchronous serial port whose bit rate comes from an 8-bit auto-reloading timer. A prescaler divides the system clock by twelve to form machine cycles, and the timer counts up once per machine cycle. On each wrap past 0xFF the timer reloads from a programmable value. Every second overflow yields one 16x oversampling tick. The transmitter advances one bit every 16 ticks. The receiver uses the same ticks to find the start edge and take a vote near the middle of each bit.

One bit therefore lasts 384 × (256 − reload) clocks. A reload of 0xFD gives 1152 clocks per bit, which is 9600 baud from an 11.0592 MHz clock. Software sets the port up through a small write port with three registers: a serial control byte, a timer mode byte and the reload value. It then moves bytes through two valid/ready streams.

On the transmit stream, `tx_ready` is high only while the port is in 8-bit asynchronous mode and no frame is in flight. A byte is taken on the edge where `tx_valid` and `tx_ready` are both high. On the receive stream, `rx_valid` holds the byte and keeps `rx_data` stable until an edge where `rx_ready` is high. Any frame that completes while the holding register is still full is dropped.

Top module: `timer_baud_uart`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 0, `rx_valid` is 0 and `ctrl_q` is 0x00.
- R2: The control byte (register address 0) selects the mode in bits [7:6]. Only the value 01 (8-bit asynchronous) makes the port operate, and `tx_ready` is high only in that mode while the transmitter is idle.
- R3: Writing 0x20 to the timer mode byte (address 1) selects auto-reload, which is bits [5:4] = 10. Writing the reload value (address 2) restarts the prescaler and the tick divider and loads the timer. A tick then follows every 24 × (256 − reload) clocks, so 0xFD gives 1152 clocks per bit.
- R4: Each frame on `txd` is a low start bit, then 8 data bits LSB first, then a high stop bit, each lasting 16 ticks. The line is high whenever the transmitter is ready.
- R5: `tx_ready` falls on the edge that accepts a byte and stays low until the stop bit has run its 16 ticks.
- R6: The transmit flag, control bit 1, is set on the edge where the stop bit starts and stays set until software clears it.
- R7: With receive enable (control bit 4) set in mode 01, a frame on `rxd` is decoded by a majority of three samples at ticks 7, 8 and 9 of each bit. On the edge where the stop-bit vote is high, the byte appears on `rx_data` with `rx_valid`, and the receive flag (control bit 0) is set. `rx_valid` holds until `rx_ready`.
- R8: With control bit 4 clear, no byte is received and the receive flag stays 0.
- R9: A low pulse on an idle line that ends before mid-bit is rejected as a false start. A disturbance on `rxd` shorter than one tick inside a bit does not corrupt the byte.
- R10: A frame that completes while `rx_valid` is high is dropped. The held byte is unchanged and the receive flag is not set.
- R11: Transmit and receive run at the same time without disturbing each other.
- R12: A control write clears a flag where the written bit is 0 and leaves it unchanged where the written bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 timer mode, 2 reload |
| cfg_wdata | input | 8 | Register write data |
| ctrl_q | output | 8 | Current control byte including both flags |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | 8 | Received byte |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |

## Verification
Every transmit result lands one clock after a tick edge or an accept edge. `txd` takes its new bit on that edge, `tx_ready` drops on the accepting edge, and the transmit flag rises on the edge where the stop bit begins. A behavioural model in the bench counts ticks from the reload write and compares all three on the falling clock edge of every cycle. Received bytes arrive about nine and a half bits after the start edge, plus two synchroniser clocks. Their checks therefore wait on `rx_valid` with a timeout, or wait a fixed span longer than a frame before confirming that nothing arrived. The measured low time of an all-zero frame bounds the bit period within one tick.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  typedef enum logic [1:0] {
    REG_SCTL   = 2'd0,
    REG_TMODE  = 2'd1,
    REG_RELOAD = 2'd2
  } reg_addr_e;

  localparam logic [1:0] SMODE_ASYNC8     = 2'b01;
  localparam logic [1:0] TMODE_AUTORELOAD = 2'b10;
  localparam int         SCTL_REN         = 4;
  localparam int         SCTL_TXF         = 1;
  localparam int         SCTL_RXF         = 0;
endpackage

// File: rtl/tbu_baud_gen.sv
module tbu_baud_gen #(
  parameter int PRESCALE     = 12,
  parameter int OVF_PER_TICK = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic       tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int DW = (OVF_PER_TICK > 1) ? $clog2(OVF_PER_TICK) : 1;

  logic [PW-1:0] pre;
  logic [DW-1:0] div;
  logic [7:0]    tl, reload;
  logic          mc, ovf;

  assign mc   = (pre == PW'(PRESCALE - 1));
  assign ovf  = run && mc && (tl == 8'hFF);
  assign tick = ovf && (div == DW'(OVF_PER_TICK - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre    <= '0;
      div    <= '0;
      tl     <= '0;
      reload <= '0;
    end else if (load) begin
      pre    <= '0;
      div    <= '0;
      tl     <= load_val;
      reload <= load_val;
    end else begin
      pre <= mc ? '0 : pre + 1'b1;
      if (run && mc) begin
        if (tl == 8'hFF) begin
          tl  <= reload;
          div <= (div == DW'(OVF_PER_TICK - 1)) ? '0 : div + 1'b1;
        end else begin
          tl <= tl + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/tbu_tx.sv
module tbu_tx #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DBITS-1:0] s_data,
  output logic             txd,
  output logic             stop_start
);
  localparam int FRAME = DBITS + 2;
  localparam int IW    = $clog2(FRAME);
  localparam int SW    = $clog2(OVS);

  logic             busy;
  logic [IW-1:0]    idx;
  logic [SW-1:0]    sub;
  logic [FRAME-1:0] shf;
  logic             bit_end;

  assign s_ready    = en && !busy;
  assign txd        = shf[0];
  assign bit_end    = busy && tick && (sub == SW'(OVS - 1));
  assign stop_start = bit_end && (idx == IW'(FRAME - 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sub  <= '0;
      shf  <= '1;
    end else if (s_valid && s_ready) begin
      busy <= 1'b1;
      idx  <= '0;
      sub  <= '0;
      shf  <= {1'b1, s_data, 1'b0};
    end else if (busy && tick) begin
      if (bit_end) begin
        sub <= '0;
        shf <= {1'b1, shf[FRAME-1:1]};
        if (idx == IW'(FRAME - 1)) busy <= 1'b0;
        else                       idx  <= idx + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbu_rx.sv
module tbu_rx #(
  parameter int OVS   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             rxd,
  input  logic             hold_free,
  output logic             got,
  output logic [DBITS-1:0] data
);
  localparam int FRAME = DBITS + 2;
  localparam int IW    = $clog2(FRAME);
  localparam int SW    = $clog2(OVS);
  localparam int MID   = OVS / 2;

  logic          s1, s2, prev, active, maj, vote_pt;
  logic [1:0]    smp;
  logic [IW-1:0] idx;
  logic [SW-1:0] sub;
  logic [DBITS-1:0] shf;

  assign maj     = (smp[0] & smp[1]) | (smp[0] & s2) | (smp[1] & s2);
  assign vote_pt = active && en && tick && (sub == SW'(MID + 1));
  assign got     = vote_pt && (idx == IW'(FRAME - 1)) && maj && hold_free;
  assign data    = shf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      active <= 1'b0;
      idx <= '0; sub <= '0; smp <= '0; shf <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) prev <= s2;
      if (!en) begin
        active <= 1'b0;
      end else if (tick) begin
        if (!active) begin
          if (prev && !s2) begin
            active <= 1'b1;
            idx    <= '0;
            sub    <= '0;
          end
        end else begin
          if (sub == SW'(MID - 1)) smp[0] <= s2;
          if (sub == SW'(MID))     smp[1] <= s2;
          if (vote_pt) begin
            if (idx == '0) begin
              if (maj) active <= 1'b0;
            end else if (idx == IW'(FRAME - 1)) begin
              active <= 1'b0;
            end else begin
              shf <= {maj, shf[DBITS-1:1]};
            end
          end
          if (sub == SW'(OVS - 1)) begin
            sub <= '0;
            idx <= idx + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/timer_baud_uart.sv
module timer_baud_uart
  import tbu_pkg::*;
#(
  parameter int PRESCALE     = 12,
  parameter int OVF_PER_TICK = 2,
  parameter int OVS          = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] ctrl_q,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       txd,
  input  logic       rxd
);
  logic [7:0] sctl;
  logic [1:0] tsel;
  logic       tick, tx_en, rx_en, tx_stop, rx_got, wr_sctl;
  logic [7:0] rx_word;

  assign wr_sctl = cfg_we && (cfg_addr == REG_SCTL);
  assign tx_en   = (sctl[7:6] == SMODE_ASYNC8);
  assign rx_en   = tx_en && sctl[SCTL_REN];
  assign ctrl_q  = sctl;

  tbu_baud_gen #(.PRESCALE(PRESCALE), .OVF_PER_TICK(OVF_PER_TICK)) u_baud (
    .clk(clk), .rst_n(rst_n),
    .run(tsel == TMODE_AUTORELOAD),
    .load(cfg_we && (cfg_addr == REG_RELOAD)),
    .load_val(cfg_wdata),
    .tick(tick)
  );

  tbu_tx #(.OVS(OVS), .DBITS(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick),
    .s_valid(tx_valid), .s_ready(tx_ready), .s_data(tx_data),
    .txd(txd), .stop_start(tx_stop)
  );

  tbu_rx #(.OVS(OVS), .DBITS(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .rxd(rxd),
    .hold_free(!rx_valid), .got(rx_got), .data(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sctl     <= '0;
      tsel     <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (wr_sctl) sctl[7:2] <= cfg_wdata[7:2];
      if (tx_stop)      sctl[SCTL_TXF] <= 1'b1;
      else if (wr_sctl) sctl[SCTL_TXF] <= sctl[SCTL_TXF] & cfg_wdata[SCTL_TXF];
      if (rx_got)       sctl[SCTL_RXF] <= 1'b1;
      else if (wr_sctl) sctl[SCTL_RXF] <= sctl[SCTL_RXF] & cfg_wdata[SCTL_RXF];
      if (cfg_we && (cfg_addr == REG_TMODE)) tsel <= cfg_wdata[5:4];
      if (rx_got) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_word;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/timer_baud_uart_chk.sv
module timer_baud_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sctl_clr_tx,
  input logic [7:0] ctrl_q,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_accept_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !txd));

  p_txflag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !sctl_clr_tx) |=> ctrl_q[1]);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind timer_baud_uart timer_baud_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .sctl_clr_tx(cfg_we && (cfg_addr == 2'd0) && !cfg_wdata[1]),
  .ctrl_q(ctrl_q), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/timer_baud_uart_bench.sv
`timescale 1ns/1ps
module timer_baud_uart_bench;
  localparam int LIMIT = 190000;
  localparam int BITC  = 384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] ctrl_q;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, txd;
  logic [7:0] tx_data = '0, rx_data;
  logic loop = 1'b1, rxd_drv = 1'b1;
  wire  rxd = loop ? txd : rxd_drv;

  int vecs = 0, fails = 0, printed = 0;

  always #10 clk = ~clk;

  timer_baud_uart u_timer_baud_uart (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .txd(txd), .rxd(rxd));

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      if (printed < 30) begin
        printed++;
        $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
    end
  endtask

  // behavioural reference of the transmit side, ticks counted from reload write
  int m_ecnt = 0, m_per = 0, m_sub = 0, m_bit = 0;
  bit m_run = 0, m_mode = 0, m_busy = 0, m_txd = 1, m_txf = 0, m_tick;
  logic [9:0] m_frame = '1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ecnt = 0; m_per = 0; m_run = 0; m_mode = 0; m_busy = 0;
      m_txd = 1; m_txf = 0; m_sub = 0; m_bit = 0;
    end else begin
      m_tick = 0;
      if (cfg_we && cfg_addr == 2'd2) begin
        m_ecnt = 0;
        m_per  = 24 * (256 - int'(cfg_wdata));
      end else begin
        m_ecnt++;
        if (m_run && m_per > 0 && (m_ecnt % m_per) == 0) m_tick = 1;
      end
      if (cfg_we && cfg_addr == 2'd0 && !cfg_wdata[1]) m_txf = 0;
      if (tx_valid && m_mode && !m_busy) begin
        m_busy = 1; m_bit = 0; m_sub = 0;
        m_frame = {1'b1, tx_data, 1'b0};
        m_txd = 0;
      end else if (m_busy && m_tick) begin
        if (m_sub == 15) begin
          m_sub = 0;
          m_bit++;
          if (m_bit == 9) m_txf = 1;
          if (m_bit == 10) begin m_busy = 0; m_txd = 1; end
          else m_txd = m_frame[m_bit];
        end else m_sub++;
      end
      if (cfg_we && cfg_addr == 2'd0) m_mode = (cfg_wdata[7:6] == 2'b01);
      if (cfg_we && cfg_addr == 2'd1) m_run  = (cfg_wdata[5:4] == 2'b10);
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R4 txd", txd, m_txd);
      check("R5/R2 tx_ready", tx_ready, m_mode && !m_busy);
      check("R6 tx flag", ctrl_q[1], m_txf);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input int max);
    for (int i = 0; i < max && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic take_rx();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic bang(input logic [7:0] b, input int spike_bit);
    logic [9:0] f;
    f = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd_drv = f[i];
      if (i == spike_bit) begin
        repeat (182) @(negedge clk);
        rxd_drv = ~f[i];
        repeat (20) @(negedge clk);
        rxd_drv = f[i];
        repeat (182) @(negedge clk);
      end else begin
        repeat (BITC) @(negedge clk);
      end
    end
  endtask

  task automatic run_all();
    int lowc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 txd", txd, 1);
    check("R1 tx_ready", tx_ready, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 ctrl_q", ctrl_q, 8'h00);
    cmp_on = 1;
    wr(2'd1, 8'h20);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h50);
    check("R2 tx_ready in mode 01", tx_ready, 1);
    // loopback byte
    send(8'hA5);
    wait_rx(6000);
    check("R7 rx_valid", rx_valid, 1);
    check("R7 rx_data", rx_data, 8'hA5);
    check("R7 rx flag", ctrl_q[0], 1);
    repeat (400) @(negedge clk);
    // flag write semantics
    wr(2'd0, 8'h53);
    check("R12 rx flag kept on write 1", ctrl_q[0], 1);
    wr(2'd0, 8'h50);
    check("R12 rx flag cleared on write 0", ctrl_q[0], 0);
    // holding full: next frame dropped
    send(8'h3C);
    repeat (5000) @(negedge clk);
    check("R10 held byte unchanged", rx_data, 8'hA5);
    check("R10 rx flag not set", ctrl_q[0], 0);
    take_rx();
    check("R7 rx_valid cleared by rx_ready", rx_valid, 0);
    // receive disabled
    wr(2'd0, 8'h40);
    send(8'h11);
    repeat (5000) @(negedge clk);
    check("R8 no byte when disabled", rx_valid, 0);
    check("R8 rx flag stays 0", ctrl_q[0], 0);
    // full duplex
    wr(2'd0, 8'h50);
    loop = 1'b0;
    fork
      send(8'h5A);
      bang(8'h96, -1);
    join
    wait_rx(2000);
    check("R11 rx during tx valid", rx_valid, 1);
    check("R11 rx during tx data", rx_data, 8'h96);
    take_rx();
    repeat (4000) @(negedge clk);
    // false start
    rxd_drv = 1'b0;
    repeat (100) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (4200) @(negedge clk);
    check("R9 false start rejected", rx_valid, 0);
    // short disturbance inside a bit
    bang(8'hC3, 4);
    wait_rx(2000);
    check("R9 spike filtered valid", rx_valid, 1);
    check("R9 spike filtered data", rx_data, 8'hC3);
    take_rx();
    // 9600-baud reload: all-zero frame, low time is nine bits within one tick
    loop = 1'b1;
    wr(2'd2, 8'hFD);
    send(8'h00);
    lowc = 1;
    while (!txd && lowc < 20000) begin @(negedge clk); lowc++; end
    check("R3 low time lower bound", (lowc >= 9*1152 - 72) ? 1 : 0, 1);
    check("R3 low time upper bound", (lowc <= 9*1152) ? 1 : 0, 1);
    wait_rx(3000);
    check("R3 byte at reload FD", rx_valid && (rx_data == 8'h00), 1);
    repeat (1500) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule